// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a memory-mapped watchdog that watches a free-running 64-bit system counter supplied on an input port. It holds a compare value. Each time software refreshes the watchdog, the compare value is set to the present counter value plus a programmable offset. If the counter reaches the compare value and no refresh has arrived, the first stage fires. It raises an interrupt level and reloads the compare value with the same offset. If the counter reaches the new compare value while the first stage is still pending, the second stage fires. It raises a reset request that holds until system reset.

Software reaches the block through a simple register port that has two frames. The refresh frame holds a single word. Writing any value to that word refreshes the watchdog. The control frame holds four registers:
- a control/status word
- a timeout offset (32 or 48 bits, chosen by the `VERSION` parameter)
- a read-only 64-bit compare value
- an identification word

A write to the control/status word or to the offset register also counts as a refresh. Reads return data in the same cycle, with no wait states.

Top module: `wdt2`

## Requirements
- R1: After reset, the enable bit, both stage flags, the offset and the compare value are all zero, and both stage outputs are low.
- R2: The control/status word at control-frame offset 0x000 reads with bit 0 = enable, bit 1 = first-stage flag and bit 2 = second-stage flag. All other bits read as zero.
- R3: A write of any data to refresh-frame offset 0x000 clears the first-stage flag. In the next cycle the compare value reads as the counter value sampled at the write plus the offset.
- R4: A write to the control/status word loads enable from data bit 0 and performs a refresh. Writing 0 stops the watchdog.
- R5: A write to the offset register (0x008 for bits 31:0; in version 1 also 0x00C for bits 47:32, taken from data bits 15:0) performs a refresh that uses the newly written offset.
- R6: While enabled, with the first-stage flag clear and no refresh in that cycle, a counter value at or above the compare value sets the first-stage flag at the next edge. The same edge reloads the compare value to counter plus offset.
- R7: While enabled, with the first-stage flag set and no refresh, a counter value at or above the compare value sets the second-stage flag. That flag stays set, through refreshes and disabling, until reset.
- R8: A refresh in the same cycle in which the first stage would fire takes priority, so the first-stage flag remains clear.
- R9: While enable is clear, neither stage flag is set, whatever the counter value.
- R10: In version 0 the offset is 32 bits: 0x00C reads as zero, and writes to it are ignored and do not refresh. In version 1 the offset is 48 bits: 0x00C returns offset bits 47:32 in bits 15:0, and bits 31:16 read as zero.
- R11: The identification word at 0xFCC holds the version in bits 19:16 and the implementer code in bits 10:0. All other bits are zero.
- R12: The compare value reads as its low word at 0x010 and its high word at 0x014.
- R13: Output `stage1_irq` is a level that equals the first-stage flag. Output `stage2_rst_req` is a level that equals the second-stage flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_count | input | 64 | Free-running system counter value |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_refresh_frame | input | 1 | 1 = refresh frame, 0 = control frame |
| bus_addr | input | 12 | Byte offset within the selected frame |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle; zero when no read is active |
| stage1_irq | output | 1 | First-stage interrupt level |
| stage2_rst_req | output | 1 | Second-stage reset request level |

## Verification
The in-module assertions check the following on every cycle:
- a refresh always leaves the first stage clear at the next edge
- an expiry with the first stage clear always raises it
- the second stage rises only after the first stage
- the second stage never drops without reset
- neither stage rises without enable

The bench scenarios show the things these properties cannot:
- the exact cycle of each stage for a sweep of offsets, computed arithmetically
- the compare arithmetic across the 32-bit word boundary
- the register layout
- the version-dependent width of the offset register, using one instance of each version

// File: rtl/wdt2.sv
module wdt2 #(
  parameter int VERSION = 1,
  parameter logic [10:0] IMPL_CODE = 11'h2A5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] sys_count,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_refresh_frame,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        stage1_irq,
  output logic        stage2_rst_req
);

  localparam logic        HAS_HI    = (VERSION != 0);
  localparam logic [3:0]  VER4      = 4'(VERSION);
  localparam logic [11:0] A_CTRL    = 12'h000;
  localparam logic [11:0] A_OFS_LO  = 12'h008;
  localparam logic [11:0] A_OFS_HI  = 12'h00C;
  localparam logic [11:0] A_CMP_LO  = 12'h010;
  localparam logic [11:0] A_CMP_HI  = 12'h014;
  localparam logic [11:0] A_IDENT   = 12'hFCC;

  logic        en, ws0, ws1;
  logic [47:0] ofs, ofs_nxt;
  logic [63:0] cmp;

  wire wr_any  = bus_sel & bus_wr;
  wire wr_ctl  = wr_any & ~bus_refresh_frame;
  wire wr_ref  = wr_any & bus_refresh_frame & (bus_addr == A_CTRL);
  wire wr_cs   = wr_ctl & (bus_addr == A_CTRL);
  wire wr_olo  = wr_ctl & (bus_addr == A_OFS_LO);
  wire wr_ohi  = wr_ctl & (bus_addr == A_OFS_HI) & HAS_HI;
  wire refresh = wr_ref | wr_cs | wr_olo | wr_ohi;
  wire expiry  = en & ~ws1 & (sys_count >= cmp);

  always_comb begin
    ofs_nxt = ofs;
    if (wr_olo) ofs_nxt[31:0]  = bus_wdata;
    if (wr_ohi) ofs_nxt[47:32] = bus_wdata[15:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      ws0 <= 1'b0;
      ws1 <= 1'b0;
      ofs <= '0;
      cmp <= '0;
    end else begin
      ofs <= ofs_nxt;
      if (wr_cs) en <= bus_wdata[0];
      if (refresh) begin
        ws0 <= 1'b0;
        cmp <= sys_count + {16'h0, ofs_nxt};
      end else if (expiry) begin
        if (!ws0) begin
          ws0 <= 1'b1;
          cmp <= sys_count + {16'h0, ofs};
        end else begin
          ws1 <= 1'b1;
        end
      end
    end
  end

  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (!bus_refresh_frame) begin
      case (bus_addr)
        A_CTRL:   rd_val = {29'h0, ws1, ws0, en};
        A_OFS_LO: rd_val = ofs[31:0];
        A_OFS_HI: rd_val = {16'h0, ofs[47:32]};
        A_CMP_LO: rd_val = cmp[31:0];
        A_CMP_HI: rd_val = cmp[63:32];
        A_IDENT:  rd_val = {12'h0, VER4, 5'h0, IMPL_CODE};
        default:  rd_val = '0;
      endcase
    end
  end

  assign bus_rdata      = (bus_sel & ~bus_wr) ? rd_val : 32'h0;
  assign stage1_irq     = ws0;
  assign stage2_rst_req = ws1;

  p_refresh_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> !stage1_irq);

  p_first_stage_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ws0 && !ws1 && !refresh && sys_count >= cmp) |=> stage1_irq);

  p_stage_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage2_rst_req) |-> $past(stage1_irq));

  p_stage2_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stage2_rst_req |=> stage2_rst_req);

  p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stage1_irq) || $rose(stage2_rst_req)) |-> $past(en));

endmodule

// File: tb/wdt2_bench.sv
module wdt2_bench;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] sys_count = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_refresh_frame = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata1, rdata0;
  logic        irq1, rst1, irq0, rst0;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt2 #(.VERSION(1), .IMPL_CODE(11'h2A5)) u_wdt2 (
    .clk, .rst_n, .sys_count, .bus_sel, .bus_wr, .bus_refresh_frame,
    .bus_addr, .bus_wdata, .bus_rdata(rdata1),
    .stage1_irq(irq1), .stage2_rst_req(rst1));

  wdt2 #(.VERSION(0), .IMPL_CODE(11'h2A5)) u_wdt2_v0 (
    .clk, .rst_n, .sys_count, .bus_sel, .bus_wr, .bus_refresh_frame,
    .bus_addr, .bus_wdata, .bus_rdata(rdata0),
    .stage1_irq(irq0), .stage2_rst_req(rst0));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic rf, input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_refresh_frame = rf; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 1'b0; bus_wr = 1'b0; bus_refresh_frame = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d1, output logic [31:0] d0);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_refresh_frame = 1'b0; bus_addr = a;
    #1;
    d1 = rdata1; d0 = rdata0;
    bus_sel = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    tick(); tick();
    do_reset();

    // R1 reset state
    rd(12'h000, a, b); chk("R1 ctrl v1", a, 0); chk("R1 ctrl v0", b, 0);
    rd(12'h008, a, b); chk("R1 ofs", a, 0);
    rd(12'h010, a, b); chk("R1 cmp", a, 0);
    chk("R1 outputs", {irq1, rst1, irq0, rst0}, 4'b0000);

    // R11 identification word
    rd(12'hFCC, a, b);
    chk("R11 ident v1", a, 32'h0001_02A5);
    chk("R11 ident v0", b, 32'h0000_02A5);

    // R6 R7 R13 sweep of offsets
    for (int o = 1; o <= 8; o++) begin
      logic [63:0] c;
      c = 64'(1000 * o);
      sys_count = c;
      wr(1'b0, 12'h008, 32'(o));
      wr(1'b0, 12'h000, 32'h1);
      rd(12'h000, a, b); chk("R4 enable set", a, 1);
      for (int k = 1; k <= 2*o + 1; k++) begin
        sys_count = c + 64'(k);
        tick();
        chk("R6 stage1 v1", irq1, (k >= o));
        chk("R7 stage2 v1", rst1, (k >= 2*o));
        chk("R13 stage1 v0", irq0, (k >= o));
        chk("R13 stage2 v0", rst0, (k >= 2*o));
      end
      rd(12'h000, a, b); chk("R2 status all set", a, 32'h7);
      wr(1'b0, 12'h000, 32'h0);
      rd(12'h000, a, b); chk("R7 stage2 sticky after stop", a, 32'h4);
      chk("R7 reset request held", rst1, 1);
      do_reset();
      rd(12'h000, a, b); chk("R1 after reset", a, 0);
    end

    // R3 refresh frame, arbitrary data
    sys_count = 64'd5000;
    wr(1'b0, 12'h008, 32'd10);
    wr(1'b0, 12'h000, 32'h1);
    sys_count = 64'd5007;
    wr(1'b1, 12'h000, 32'hDEADBEEF);
    rd(12'h010, a, b); chk("R3 cmp reload", a, 32'd5017);
    sys_count = 64'd5017;
    tick();
    chk("R6 stage1 fired", irq1, 1);
    sys_count = 64'd5018;
    wr(1'b1, 12'h000, 32'h0);
    chk("R3 refresh clears stage1", irq1, 0);
    rd(12'h010, a, b); chk("R3 cmp after refresh", a, 32'd5028);

    // R8 refresh in the expiry cycle
    sys_count = 64'd5028;
    wr(1'b1, 12'h000, 32'h5A5A5A5A);
    chk("R8 race stage1", irq1, 0);
    rd(12'h000, a, b); chk("R8 status", a, 32'h1);
    rd(12'h010, a, b); chk("R8 cmp", a, 32'd5038);

    // R5 offset write refreshes with new value
    sys_count = 64'd6000;
    wr(1'b0, 12'h008, 32'd20);
    rd(12'h010, a, b); chk("R5 cmp new offset", a, 32'd6020);

    // R12 compare crosses 32-bit boundary
    sys_count = 64'h0000_0003_FFFF_FFF0;
    wr(1'b0, 12'h008, 32'h40);
    rd(12'h010, a, b); chk("R12 cmp low", a, 32'h30); chk("R12 cmp low v0", b, 32'h30);
    rd(12'h014, a, b); chk("R12 cmp high", a, 32'h4); chk("R12 cmp high v0", b, 32'h4);

    // R10 offset width by version
    wr(1'b0, 12'h00C, 32'hFFFF_0002);
    rd(12'h00C, a, b);
    chk("R10 v1 upper offset", a, 32'h0000_0002);
    chk("R10 v0 upper offset", b, 32'h0);
    rd(12'h014, a, b);
    chk("R10 v1 refresh 48-bit", a, 32'h6);
    chk("R10 v0 write ignored", b, 32'h4);
    rd(12'h008, a, b); chk("R10 v0 low offset kept", b, 32'h40);

    // R9 disabled watchdog stays quiet
    wr(1'b0, 12'h000, 32'h0);
    sys_count = 64'hFFFF_FFFF_FFFF_0000;
    tick(); tick(); tick();
    chk("R9 outputs quiet", {irq1, rst1, irq0, rst0}, 4'b0000);
    rd(12'h000, a, b); chk("R9 status", a, 0); chk("R9 status v0", b, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule